// File: doc/BRIEF.md
# Bit-Serial Linear-Phase 24-Tap FIR Filter

This block filters a stream of two's-complement samples that arrive one bit per clock, least significant bit first. The 24 coefficients are mirror images of each other around the centre of the impulse response, so only twelve values are stored, and they are fixed by a parameter. Each sample occupies a frame of `FRAME` clocks. A one-clock `init` pulse marks the clock that carries a sample's first bit. Every frame produces one full-precision result, which leaves the block on `dout` LSB first.

The tap chain is built from three identical sections of eight taps each. Each section holds four forward sample delays and four returning sample delays. The forward chain passes on to the next section. The returning chain comes back from it. In the last section the end of the forward chain is wired to the start of the returning chain, which folds the line. Inside each section, every pair of mirrored taps is summed serially before weighting. The three section streams are then merged by a serial carry-save stage and one final serial adder.

Top module: `bsfir24`

## Requirements
- R1: For the frame of sample n, the output word read as an F-bit two's-complement number equals sum over k=0..23 of h(k)*x[n-k]. Samples before the first frame after reset count as zero. h(k)=h(23-k), and for k in 0..11 the value h(k) is the signed `COEF_W`-bit field `COEFS[k*COEF_W +: COEF_W]`.
- R2: The coefficients are symmetric. A single sample of value 1 followed by zeros gives the outputs h(0)..h(11) and then h(11)..h(0) over 24 frames, followed by zero.
- R3: Input is serial and LSB first. `init` is high for exactly one clock, together with bit 0, and frames repeat every `FRAME` clocks.
- R4: Suppose `init` is sampled at rising edge e. Then result bit b is on `dout` after edge e+2+b, and before edge e+2 `dout` still carries earlier data.
- R5: Input bits at positions `SAMPLE_W`..`FRAME-1` of a frame are ignored. The sample is sign-extended from bit `SAMPLE_W-1`.
- R6: `init` restarts all per-frame arithmetic (pair-adder carries, weighting accumulators, merge carries), so no carry crosses from one frame's result into the next.
- R7: Synchronous reset clears every delay bit, carry and accumulator. `dout` is 0 during and after reset until a frame completes, and later results match an all-zero history.
- R8: Worst-case inputs (-2^(SAMPLE_W-1) and 2^(SAMPLE_W-1)-1) give exact results. Result bits at positions above `SAMPLE_W+COEF_W+4` repeat the sign.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| init | input | 1 | One-clock frame marker, coincident with the sample LSB |
| din | input | 1 | Serial sample input, LSB first |
| dout | output | 1 | Serial full-precision result, LSB first |

## Verification
A wrong carry or accumulator value shows up in the result word of the frame where it occurs. It corrupts the bit at that position and every higher bit, and the error appears two clocks after the affected input bit. A broken delay or a wrong fold corrupts later frames instead. The impulse run exposes this as a misplaced or missing coefficient, 1 to 23 frames after the impulse. A carry that leaks across a frame boundary changes the LSB of the following word, so back-to-back extreme samples reveal it within one frame.

// File: rtl/bsfir_pkg.sv
package bsfir_pkg;

    localparam int NUM_TAPS       = 24;
    localparam int NUM_UNIQUE     = NUM_TAPS / 2;
    localparam int NUM_SECT       = 3;
    localparam int PAIRS_PER_SECT = NUM_UNIQUE / NUM_SECT;

    // one bit-serial full-adder step: sum bit and carry into next weight
    typedef struct packed {
        logic sum;
        logic cy;
    } fa_t;

    function automatic fa_t full_add(input logic a, input logic b, input logic ci);
        fa_t r;
        r.sum = a ^ b ^ ci;
        r.cy  = (a & b) | (a & ci) | (b & ci);
        return r;
    endfunction

endpackage

// File: rtl/bsfir_frame_delay.sv
module bsfir_frame_delay #(
    parameter int FRAME = 24
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);

    logic [FRAME-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= '0;
        end else begin
            sr_q <= {sr_q[FRAME-2:0], din};
        end
    end

    assign dout = sr_q[FRAME-1];

endmodule

// File: rtl/bsfir_section.sv
module bsfir_section
    import bsfir_pkg::*;
#(
    parameter int CW    = 8,
    parameter int FRAME = 24,
    parameter logic [PAIRS_PER_SECT*CW-1:0] COEFS = '0
) (
    input  logic clk,
    input  logic rst,
    input  logic first,
    input  logic fwd_in,
    input  logic ret_in,
    output logic fwd_out,
    output logic ret_out,
    output logic prod_out
);

    localparam int NP = PAIRS_PER_SECT;
    localparam int AW = CW + 4;

    function automatic int mag_sum(input logic [NP*CW-1:0] v);
        int t;
        t = 0;
        for (int j = 0; j < NP; j++) begin
            int c;
            c = int'($signed(v[j*CW +: CW]));
            t = t + ((c < 0) ? -c : c);
        end
        return t;
    endfunction

    localparam int BOUND = mag_sum(COEFS);

    // forward and returning sample delays
    logic [NP:0] fw, rw;
    assign fw[0] = fwd_in;
    assign rw[0] = ret_in;

    for (genvar g = 0; g < NP; g++) begin : g_dly
        bsfir_frame_delay #(.FRAME(FRAME)) u_fwd (
            .clk (clk),
            .rst (rst),
            .din (fw[g]),
            .dout(fw[g+1])
        );
        bsfir_frame_delay #(.FRAME(FRAME)) u_ret (
            .clk (clk),
            .rst (rst),
            .din (rw[g]),
            .dout(rw[g+1])
        );
    end

    assign fwd_out = fw[NP];
    assign ret_out = rw[NP];

    // serial pre-add of mirrored taps
    logic [NP-1:0] pair_bit, pc_d, pc_q;

    for (genvar g = 0; g < NP; g++) begin : g_pre
        assign {pair_bit[g], pc_d[g]} =
            full_add(fw[g], rw[NP-1-g], first ? 1'b0 : pc_q[g]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_d;
        end
    end

    // serial-by-constant weighting: accumulate selected coefficients, shift out LSB
    logic signed [AW-1:0] acc_q, acc_in, mac_sum;
    logic                 prod_q;

    always_comb begin
        acc_in  = first ? '0 : acc_q;
        mac_sum = acc_in;
        for (int j = 0; j < NP; j++) begin
            if (pair_bit[j]) begin
                mac_sum = mac_sum + AW'($signed(COEFS[j*CW +: CW]));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            prod_q <= 1'b0;
        end else begin
            acc_q  <= mac_sum >>> 1;
            prod_q <= mac_sum[0];
        end
    end

    assign prod_out = prod_q;

    // R8
    acc_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_q <= BOUND) && (acc_q >= -BOUND));

endmodule

// File: rtl/bsfir_merge.sv
module bsfir_merge
    import bsfir_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                first,
    input  logic [NUM_SECT-1:0] terms,
    output logic                dout
);

    fa_t  csa, fin;
    logic cs_q, fc_q, dout_q;

    // carry-save: three streams -> sum stream plus carry stream one weight up
    assign csa = full_add(terms[0], terms[1], terms[2]);
    // final serial adder resolves sum and delayed carry
    assign fin = full_add(csa.sum, first ? 1'b0 : cs_q, first ? 1'b0 : fc_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q   <= 1'b0;
            fc_q   <= 1'b0;
            dout_q <= 1'b0;
        end else begin
            cs_q   <= csa.cy;
            fc_q   <= fin.cy;
            dout_q <= fin.sum;
        end
    end

    assign dout = dout_q;

endmodule

// File: rtl/bsfir24.sv
module bsfir24
    import bsfir_pkg::*;
#(
    parameter int SAMPLE_W = 8,
    parameter int COEF_W   = 8,
    parameter int FRAME    = SAMPLE_W + COEF_W + 8,
    parameter logic [NUM_UNIQUE*COEF_W-1:0] COEFS =
        {8'h7F, 8'h64, 8'h40, 8'h28, 8'h1C, 8'hEC,
         8'h0F, 8'hF4, 8'h09, 8'hF9, 8'h05, 8'hFD}
) (
    input  logic clk,
    input  logic rst,
    input  logic init,
    input  logic din,
    output logic dout
);

    localparam int PW       = $clog2(FRAME) + 1;
    localparam logic [PW-1:0] POS_IDLE = '1;
    localparam int SECT_CW  = PAIRS_PER_SECT * COEF_W;
    localparam int SIGN_POS = SAMPLE_W + COEF_W + 4;

    if (FRAME < SAMPLE_W + COEF_W + 5) begin : g_bad_frame
        $error("FRAME too short for full-precision result");
    end

    // frame position tracking and input sign extension
    logic [PW-1:0] pos_in, pos_q, pos_d1, pos_d2;
    logic          msb_q, msb_d, ext_bit, xs_q;

    always_comb begin
        pos_in  = init ? '0 : ((pos_q == POS_IDLE) ? pos_q : pos_q + 1'b1);
        ext_bit = (pos_in < PW'(SAMPLE_W)) ? din : msb_q;
        msb_d   = (pos_in == PW'(SAMPLE_W - 1)) ? din : msb_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q  <= POS_IDLE;
            pos_d1 <= POS_IDLE;
            pos_d2 <= POS_IDLE;
            msb_q  <= 1'b0;
            xs_q   <= 1'b0;
        end else begin
            pos_q  <= pos_in;
            pos_d1 <= pos_q;
            pos_d2 <= pos_d1;
            msb_q  <= msb_d;
            xs_q   <= ext_bit;
        end
    end

    logic sect_first, merge_first;
    assign sect_first  = (pos_q == '0);
    assign merge_first = (pos_d1 == '0);

    // cascaded sections with folded delay line
    logic [NUM_SECT-1:0] fwd_i, fwd_o, ret_i, ret_o, prod;
    logic                ret_tail_unused;
    assign ret_tail_unused = ret_o[0];

    for (genvar s = 0; s < NUM_SECT; s++) begin : g_sect
        if (s == 0) begin : g_head
            assign fwd_i[s] = xs_q;
        end else begin : g_link
            assign fwd_i[s] = fwd_o[s-1];
        end
        if (s == NUM_SECT - 1) begin : g_fold
            assign ret_i[s] = fwd_o[s];
        end else begin : g_back
            assign ret_i[s] = ret_o[s+1];
        end

        bsfir_section #(
            .CW   (COEF_W),
            .FRAME(FRAME),
            .COEFS(COEFS[s*SECT_CW +: SECT_CW])
        ) u_sect (
            .clk     (clk),
            .rst     (rst),
            .first   (sect_first),
            .fwd_in  (fwd_i[s]),
            .ret_in  (ret_i[s]),
            .fwd_out (fwd_o[s]),
            .ret_out (ret_o[s]),
            .prod_out(prod[s])
        );
    end

    bsfir_merge u_merge (
        .clk  (clk),
        .rst  (rst),
        .first(merge_first),
        .terms(prod),
        .dout (dout)
    );

    // R3
    init_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        init |=> !init);

    // R5
    in_sext_chk: assert property (@(posedge clk) disable iff (rst)
        (pos_q > PW'(SAMPLE_W) && pos_q < PW'(FRAME)) |-> (xs_q == $past(xs_q)));

    // R8
    out_sext_chk: assert property (@(posedge clk) disable iff (rst)
        (pos_d2 > PW'(SIGN_POS) && pos_d2 < PW'(FRAME)) |-> (dout == $past(dout)));

endmodule

// File: tb/bsfir24_tb.sv
module bsfir24_tb;

    localparam int CLK_PERIOD = 10;
    localparam int W    = 8;
    localparam int FR   = 24;
    localparam int LAT  = 2;
    localparam int MAXF = 128;
    localparam longint MASK = (64'sd1 <<< FR) - 1;

    logic clk, rst, init, din, dout;

    int checks   = 0;
    int failures = 0;
    int samp [MAXF];
    bit tail_rand;
    logic [31:0] lf = 32'h1ACE_5EED;

    bsfir24 u_dut (
        .clk (clk),
        .rst (rst),
        .init(init),
        .din (din),
        .dout(dout)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic int h_of(input int k);
        int m;
        int tbl [12] = '{-3, 5, -7, 9, -12, 15, -20, 28, 40, 64, 100, 127};
        m = (k < 12) ? k : 23 - k;
        return tbl[m];
    endfunction

    function automatic longint ref_y(input int n);
        longint acc;
        acc = 0;
        for (int k = 0; k < 24; k++) begin
            if (n - k >= 0) acc = acc + longint'(h_of(k)) * longint'(samp[n-k]);
        end
        return acc;
    endfunction

    function automatic bit rbit();
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        return lf[0];
    endfunction

    function automatic int rsamp();
        for (int i = 0; i < 8; i++) void'(rbit());
        return int'($signed(lf[7:0]));
    endfunction

    task automatic check(input bit ok, input string what, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst  = 1'b1;
        init = 1'b0;
        din  = 1'b0;
        repeat (3) @(negedge clk);
        check(dout == 1'b0, "R7 dout during reset", longint'(dout), 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        check(dout == 1'b0, "R7 dout idle after reset", longint'(dout), 0);
    endtask

    task automatic run_frames(input int nf, input string req, input bit probe);
        longint word;
        word = 0;
        for (int c = 0; c < nf * FR + LAT + 1; c++) begin
            @(negedge clk);
            if (probe && c == LAT)
                check(dout == 1'b0, "R4 bit0 not yet out", longint'(dout), 0);
            if (probe && c == LAT + 1)
                check(dout == ref_y(0)[0], "R4 bit0 at latency", longint'(dout), ref_y(0) & 1);
            if (c >= LAT + 1) begin
                int oc, of, ob;
                oc = c - LAT - 1;
                of = oc / FR;
                ob = oc % FR;
                if (ob == 0) word = 0;
                word = word | (longint'(dout) << ob);
                if (ob == FR - 1) begin
                    longint e;
                    e = ref_y(of) & MASK;
                    check(word == e, $sformatf("%s frame %0d", req, of), word, e);
                end
            end
            if (c < nf * FR) begin
                int f, b;
                f = c / FR;
                b = c % FR;
                init = (b == 0);
                if (b < W) din = samp[f][b];
                else if (tail_rand) din = rbit();
                else din = samp[f][W-1];
            end else begin
                init = 1'b0;
                din  = 1'b0;
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 40000);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; init = 1'b0; din = 1'b0;

        // R7 reset state; R2 impulse response and symmetry; R4 latency
        do_reset();
        for (int i = 0; i < 25; i++) samp[i] = (i == 0) ? 1 : 0;
        tail_rand = 1'b0;
        run_frames(25, "R2 R1 impulse", 1'b1);

        // R8 extremes, R6 per-frame restart with back-to-back carries, R5 garbage tails
        do_reset();
        for (int i = 0; i < 72; i++) begin
            if (i < 24) samp[i] = -128;
            else if (i < 48) samp[i] = 127;
            else samp[i] = (i % 2 == 0) ? -128 : 127;
        end
        tail_rand = 1'b1;
        run_frames(72, "R8 R6 extremes", 1'b0);

        // R1 R3 R5 random samples with random bits past the MSB
        do_reset();
        for (int i = 0; i < 100; i++) samp[i] = rsamp();
        tail_rand = 1'b1;
        run_frames(100, "R1 R3 R5 random", 1'b0);

        // R7 reset after busy history: results must match an all-zero past
        do_reset();
        for (int i = 0; i < 30; i++) samp[i] = rsamp();
        tail_rand = 1'b0;
        run_frames(30, "R7 after reset", 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule